// File: doc/BRIEF.md
# Snooping Four-Way Instruction Cache

This block is a read-only instruction cache of 16 KB. It holds 128 sets of four ways, and each line is 32 bytes with its own tag. A fetch presents a virtual address and, in the same cycle, the physical page number that the translation buffer has just produced. The set is chosen from page-offset bits only. Because of this, the tag lookup runs alongside the translation and the physical tag is compared as soon as it arrives. On a hit the block returns the whole 32-byte line one cycle later.

On a miss the block reports the miss and asks a simple memory port for the line. While the fill is in progress it stops accepting fetches. When the line arrives it is written into a victim way. An empty way is used first. If no way is empty, a three-bit tree pseudo-LRU state kept per set picks the victim.

A second tag port takes snoop addresses every cycle, independently of fetches and fills. It clears the valid bit of any line whose physical address matches. A snoop that names the line currently being fetched from memory lets that fill finish but leaves the line invalid.

Top module: `icache_snoop4w`

## Requirements
- R1: The cache holds 4 ways × 128 sets × 32-byte lines. The set is `fetch_vaddr[11:5]`. The tag compared is `fetch_ptag`, which is physical address bits [31:12], taken in the same cycle as the fetch.
- R2: A fetch is accepted when `fetch_valid` and `fetch_ready` are both high. One cycle later `resp_valid` is high. On a hit `resp_hit` is high and `resp_line` equals the 256-bit line exactly as it was delivered on `mem_resp_data`. No response appears without an accepted fetch.
- R3: After an accepted fetch misses, `resp_hit` is low. In the same cycle `mem_req_valid` is high with `mem_req_addr` = {ptag, set, 5'b0}. The request stays high with a stable address until `mem_req_ready` is sampled high.
- R4: From the miss until the cycle after `mem_resp_valid`, `fetch_ready` is low. It is high again from the next cycle. The filled line then hits.
- R5: A fill goes into the lowest-numbered invalid way of the set, so four different lines fill one set without evicting each other.
- R6: When all ways are valid, the victim comes from 3 state bits per set. Bit 0 = 0 selects ways {0,1} and bit 0 = 1 selects ways {2,3}. Bit 1 picks way 0 (0) or way 1 (1). Bit 2 picks way 2 (0) or way 3 (1). Every hit and every fill sets the bits to point away from the way used.
- R7: A snoop (`snoop_valid`) whose `snoop_paddr[11:5]` and `snoop_paddr[31:12]` match a valid line clears that line. A later fetch of that line misses. Snoops never stall fetches.
- R8: When a fetch and a snoop name the same line in the same cycle, the fetch still returns a hit with the line's data. The line is invalid from the next cycle.
- R9: A snoop that matches the address of the line being filled, from the miss cycle through the install cycle, lets the fill complete but leaves the line invalid. The next fetch of it misses.
- R10: After reset every line is invalid and all replacement bits are zero. `fetch_ready` is high, and `mem_req_valid` and `resp_valid` are low.
- R11: A snoop whose tag or set differs from a cached line leaves that line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request |
| fetch_ready | output | 1 | High when a fetch can be accepted (no fill running) |
| fetch_vaddr | input | 32 | Virtual fetch address; bits [11:5] pick the set |
| fetch_ptag | input | 20 | Physical page number from translation, same cycle |
| resp_valid | output | 1 | Response for the fetch accepted one cycle earlier |
| resp_hit | output | 1 | Response was a hit |
| resp_line | output | 256 | Full line on a hit, zero otherwise |
| mem_req_valid | output | 1 | Line fill request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Line-aligned physical address to fill |
| mem_resp_valid | input | 1 | Fill data present |
| mem_resp_data | input | 256 | Fill data, byte 0 in bits [7:0] |
| snoop_valid | input | 1 | Snoop address present |
| snoop_paddr | input | 32 | Physical snoop address |

## Verification
Two pairs of functions can act in the same cycle here. A fetch can look up a line while the snoop port clears that same line, and a snoop can land on a line whose fill is in flight. The bench provokes the first pair by driving a fetch and a matching snoop on the same clock edge. It passes when that fetch returns a hit with correct data and a repeat fetch of the line misses. For the second pair, the bench drives a matching snoop after the request is accepted but before the data returns. It passes when the fill still completes and the line is then refetched from memory.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int TREE_W = 3;

  typedef logic [TREE_W-1:0] tree_t;
  typedef logic [WAY_W-1:0]  way_t;

  // Victim from the tree bits: bit0 picks the pair, bit1/bit2 pick within it.
  function automatic way_t tree_pick(input tree_t s);
    return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
  endfunction

  // Point every bit on the path away from the way just used.
  function automatic tree_t tree_touch(input tree_t s, input way_t w);
    tree_t n;
    n    = s;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
  import icache_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  // fetch compare port
  input  logic [IDX_W-1:0] f_idx,
  input  logic [TAG_W-1:0] f_tag,
  output logic [WAYS-1:0]  f_hit_vec,
  output logic [WAYS-1:0]  f_vld_vec,
  // snoop compare port
  input  logic             s_en,
  input  logic [IDX_W-1:0] s_idx,
  input  logic [TAG_W-1:0] s_tag,
  // install port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  way_t             wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  s_hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign f_hit_vec[w] = vld_q[f_idx][w] && (tag_q[f_idx][w] == f_tag);
    assign s_hit_vec[w] = vld_q[s_idx][w] && (tag_q[s_idx][w] == s_tag);
  end
  assign f_vld_vec = vld_q[f_idx];

  // Valid bits: snoop clears, install written last so it wins on its own bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) vld_q[i] <= '0;
    end else begin
      if (s_en) vld_q[s_idx] <= vld_q[s_idx] & ~s_hit_vec;
      if (wr_en) vld_q[wr_idx][wr_way] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
  end
endmodule

// File: rtl/icache_line_ram.sv
module icache_line_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/icache_repl.sv
module icache_repl
  import icache_pkg::*;
#(
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [WAYS-1:0]  rd_vld,
  output way_t             victim,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  way_t             upd_way
);
  tree_t tree_q [SETS];

  // Empty way first (lowest index), else the tree choice.
  always_comb begin
    victim = tree_pick(tree_q[rd_idx]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!rd_vld[w]) victim = way_t'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) tree_q[i] <= '0;
    end else if (upd_en) begin
      tree_q[upd_idx] <= tree_touch(tree_q[upd_idx], upd_way);
    end
  end
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int TAG_W  = 20,
  localparam int OFF_W = ADDR_W - IDX_W - TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_fire,
  input  logic [IDX_W-1:0]  miss_idx,
  input  logic [TAG_W-1:0]  miss_tag,
  input  way_t              miss_way,
  input  logic              s_en,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic [TAG_W-1:0]  s_tag,
  output logic              idle,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  output logic              ins_en,
  output logic [IDX_W-1:0]  ins_idx,
  output way_t              ins_way,
  output logic [TAG_W-1:0]  ins_tag,
  output logic              ins_valid
);
  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_WAIT} fstate_t;

  fstate_t          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  way_t             way_q;
  logic             kill_q;
  logic             snoop_on_fill;

  assign snoop_on_fill = s_en && (s_idx == idx_q) && (s_tag == tag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FS_IDLE;
      kill_q <= 1'b0;
      idx_q  <= '0;
      tag_q  <= '0;
      way_q  <= '0;
    end else begin
      case (st_q)
        FS_IDLE: if (miss_fire) begin
          st_q   <= FS_REQ;
          idx_q  <= miss_idx;
          tag_q  <= miss_tag;
          way_q  <= miss_way;
          kill_q <= s_en && (s_idx == miss_idx) && (s_tag == miss_tag);
        end
        FS_REQ: begin
          if (snoop_on_fill) kill_q <= 1'b1;
          if (mem_req_ready) st_q <= FS_WAIT;
        end
        FS_WAIT: begin
          if (snoop_on_fill) kill_q <= 1'b1;
          if (mem_resp_valid) st_q <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign idle          = (st_q == FS_IDLE);
  assign mem_req_valid = (st_q == FS_REQ);
  assign mem_req_addr  = {tag_q, idx_q, {OFF_W{1'b0}}};
  assign ins_en        = (st_q == FS_WAIT) && mem_resp_valid;
  assign ins_idx       = idx_q;
  assign ins_way       = way_q;
  assign ins_tag       = tag_q;
  assign ins_valid     = !(kill_q || snoop_on_fill);
endmodule

// File: rtl/icache_snoop4w.sv
module icache_snoop4w
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_vaddr,
  input  logic [TAG_W-1:0]  fetch_ptag,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [LINE_W-1:0] resp_line,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [LINE_W-1:0] mem_resp_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_paddr
);
  logic [IDX_W-1:0]  f_idx, s_idx;
  logic [TAG_W-1:0]  s_tag;
  logic [WAYS-1:0]   hit_vec, vld_vec;
  logic              hit, fire, miss_fire;
  way_t              hit_way, victim, hit_way_q, upd_way;
  logic              ins_en, ins_valid;
  logic [IDX_W-1:0]  ins_idx, upd_idx;
  way_t              ins_way;
  logic [TAG_W-1:0]  ins_tag;
  logic              idle;
  logic [LINE_W-1:0] rd_line [WAYS];
  logic              unused_addr_bits;

  assign f_idx = fetch_vaddr[OFF_W +: IDX_W];
  assign s_idx = snoop_paddr[OFF_W +: IDX_W];
  assign s_tag = snoop_paddr[ADDR_W-1 -: TAG_W];
  assign unused_addr_bits = ^{fetch_vaddr[ADDR_W-1:OFF_W+IDX_W],
                              fetch_vaddr[OFF_W-1:0], snoop_paddr[OFF_W-1:0]};

  assign fetch_ready = idle;
  assign fire        = fetch_valid && idle;
  assign hit         = |hit_vec;
  assign miss_fire   = fire && !hit;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = way_t'(w);
    end
  end

  icache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst(rst),
    .f_idx(f_idx), .f_tag(fetch_ptag), .f_hit_vec(hit_vec), .f_vld_vec(vld_vec),
    .s_en(snoop_valid), .s_idx(s_idx), .s_tag(s_tag),
    .wr_en(ins_en), .wr_idx(ins_idx), .wr_way(ins_way), .wr_tag(ins_tag),
    .wr_valid(ins_valid)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    icache_line_ram #(.DEPTH(SETS), .WIDTH(LINE_W)) ram_i (
      .clk(clk),
      .we(ins_en && (ins_way == way_t'(w))), .waddr(ins_idx), .wdata(mem_resp_data),
      .re(fire), .raddr(f_idx), .rdata(rd_line[w])
    );
  end

  assign upd_idx = ins_en ? ins_idx : f_idx;
  assign upd_way = ins_en ? ins_way : hit_way;

  icache_repl #(.SETS(SETS)) repl_i (
    .clk(clk), .rst(rst),
    .rd_idx(f_idx), .rd_vld(vld_vec), .victim(victim),
    .upd_en(ins_en || (fire && hit)), .upd_idx(upd_idx), .upd_way(upd_way)
  );

  icache_fill_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) fill_i (
    .clk(clk), .rst(rst),
    .miss_fire(miss_fire), .miss_idx(f_idx), .miss_tag(fetch_ptag), .miss_way(victim),
    .s_en(snoop_valid), .s_idx(s_idx), .s_tag(s_tag),
    .idle(idle), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .ins_en(ins_en), .ins_idx(ins_idx), .ins_way(ins_way), .ins_tag(ins_tag),
    .ins_valid(ins_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      hit_way_q  <= '0;
    end else begin
      resp_valid <= fire;
      resp_hit   <= fire && hit;
      if (fire) hit_way_q <= hit_way;
    end
  end

  assign resp_line = resp_hit ? rd_line[hit_way_q] : '0;
endmodule

// File: rtl/icache_snoop4w_chk.sv
module icache_snoop4w_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr
);
  a_r2_resp_after_fire: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_ready) |=> resp_valid);
  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !(fetch_valid && fetch_ready) |=> !resp_valid);
  a_r2_hit_needs_resp: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_valid);
  a_r3_miss_requests: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> mem_req_valid);
  a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r4_stall_in_fill: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !fetch_ready);
endmodule

bind icache_snoop4w icache_snoop4w_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/icache_snoop4w_tb_top.sv
module icache_snoop4w_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fetch_valid = 1'b0;
  logic         fetch_ready;
  logic [31:0]  fetch_vaddr = '0;
  logic [19:0]  fetch_ptag = '0;
  logic         resp_valid, resp_hit;
  logic [255:0] resp_line;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_resp_valid = 1'b0;
  logic [255:0] mem_resp_data = '0;
  logic         snoop_valid = 1'b0;
  logic [31:0]  snoop_paddr = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  icache_snoop4w dut_i (.*);

  // {vaddr, ptag, expected hit}; set 5 runs the replacement sequence (R6),
  // set 9 shows four fills coexisting (R5).
  localparam logic [52:0] VEC [NVEC] = '{
    {32'h0000_00A4, 20'h00A0A, 1'b0}, {32'h0000_00A4, 20'h0B0B0, 1'b0},
    {32'h0000_00A4, 20'h0C0C0, 1'b0}, {32'h0000_00A4, 20'h0D0D0, 1'b0},
    {32'h0000_00A4, 20'h0E0E0, 1'b0}, {32'h0000_00A4, 20'h0B0B0, 1'b1},
    {32'h0000_00A4, 20'h0C0C0, 1'b1}, {32'h0000_00A4, 20'h0D0D0, 1'b1},
    {32'h0000_00A4, 20'h00A0A, 1'b0}, {32'h0000_00A4, 20'h0E0E0, 1'b0},
    {32'h0000_00A4, 20'h0B0B0, 1'b1}, {32'h0000_00A4, 20'h0D0D0, 1'b1},
    {32'h0000_00A4, 20'h00A0A, 1'b1}, {32'h0000_00A4, 20'h0C0C0, 1'b0},
    {32'h7777_7128, 20'h00001, 1'b0}, {32'h7777_7128, 20'h00002, 1'b0},
    {32'h7777_7128, 20'h00003, 1'b0}, {32'h7777_7128, 20'h00004, 1'b0},
    {32'h7777_7128, 20'h00001, 1'b1}, {32'h7777_7128, 20'h00002, 1'b1},
    {32'h7777_7128, 20'h00003, 1'b1}, {32'h7777_7128, 20'h00004, 1'b1},
    {32'h0000_0000, 20'h12345, 1'b0}, {32'h0000_0000, 20'h12345, 1'b1},
    {32'h0000_0FE0, 20'hFFFFF, 1'b0}, {32'h0000_0FE0, 20'hFFFFF, 1'b1}
  };

  function automatic logic [255:0] line_of(input logic [31:0] a);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = a ^ (32'h9E37_79B9 * (k + 1));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Serve one fill; request is expected visible at the current negedge.
  task automatic serve_fill(input logic [31:0] exp_addr, input bit snoop_mid);
    chk(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R3 request address",
        {mem_req_valid, mem_req_addr}, {1'b1, exp_addr});
    chk(fetch_ready === 1'b0, "R4 stalled during fill", fetch_ready, 0);
    @(negedge clk);
    chk(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R3 request held",
        {mem_req_valid, mem_req_addr}, {1'b1, exp_addr});
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    if (snoop_mid) begin
      snoop_valid = 1'b1;
      snoop_paddr = exp_addr;
      @(negedge clk);
      snoop_valid = 1'b0;
    end
    mem_resp_valid = 1'b1;
    mem_resp_data  = line_of(exp_addr);
    @(negedge clk);
    mem_resp_valid = 1'b0;
    chk(fetch_ready === 1'b1, "R4 ready after fill", fetch_ready, 1);
  endtask

  task automatic access(input logic [31:0] va, input logic [19:0] pt, input bit exp_hit,
                        input string req, input bit snoop_same, input bit snoop_mid);
    logic [31:0] la;
    la = {pt, va[11:5], 5'b0};
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_vaddr = va;
    fetch_ptag  = pt;
    if (snoop_same) begin
      snoop_valid = 1'b1;
      snoop_paddr = la;
    end
    @(negedge clk);
    fetch_valid = 1'b0;
    snoop_valid = 1'b0;
    chk(resp_valid === 1'b1, {req, " response valid"}, resp_valid, 1);
    chk(resp_hit === exp_hit, {req, " hit/miss"}, resp_hit, exp_hit);
    if (resp_hit === 1'b1)
      chk(resp_line === line_of(la), {req, " line data"}, resp_line, line_of(la));
    if (resp_hit !== 1'b1 && mem_req_valid === 1'b1) serve_fill(la, snoop_mid);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state at the ports
    chk(fetch_ready === 1'b1, "R10 ready after reset", fetch_ready, 1);
    chk(mem_req_valid === 1'b0, "R10 no request after reset", mem_req_valid, 0);
    chk(resp_valid === 1'b0, "R10 no response after reset", resp_valid, 0);

    for (int i = 0; i < NVEC; i++)
      access(VEC[i][52:21], VEC[i][20:1], VEC[i][0], "R1 R2 R5 R6 vector", 1'b0, 1'b0);

    // R11: non-matching snoops (other tag, other set) leave line valid
    @(negedge clk);
    snoop_valid = 1'b1; snoop_paddr = {20'hFFFFE, 7'd127, 5'd0};
    @(negedge clk);
    snoop_paddr = {20'hFFFFF, 7'd126, 5'd0};
    @(negedge clk);
    snoop_valid = 1'b0;
    access(32'h0000_0FE0, 20'hFFFFF, 1'b1, "R11 survives foreign snoop", 1'b0, 1'b0);

    // R7: matching snoop clears the line
    @(negedge clk);
    snoop_valid = 1'b1; snoop_paddr = {20'h12345, 7'd0, 5'd0};
    @(negedge clk);
    snoop_valid = 1'b0;
    access(32'h0000_0004, 20'h12345, 1'b0, "R7 miss after snoop", 1'b0, 1'b0);
    access(32'h0000_0004, 20'h12345, 1'b1, "R7 refilled", 1'b0, 1'b0);

    // R8: fetch and snoop of the same line in one cycle
    access(32'h0000_0FE0, 20'hFFFFF, 1'b1, "R8 same-cycle fetch hit", 1'b1, 1'b0);
    access(32'h0000_0FE0, 20'hFFFFF, 1'b0, "R8 invalid next cycle", 1'b0, 1'b0);
    access(32'h0000_0FE0, 20'hFFFFF, 1'b1, "R8 refilled", 1'b0, 1'b0);

    // R9: snoop on the in-flight line
    access(32'h0000_0280, 20'h55555, 1'b0, "R9 miss with snoop in fill", 1'b0, 1'b1);
    access(32'h0000_0280, 20'h55555, 1'b0, "R9 killed fill misses", 1'b0, 1'b0);
    access(32'h0000_0280, 20'h55555, 1'b1, "R9 clean fill hits", 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule